// File: doc/BRIEF.md
# Two-Way Set-Associative Read/Write Cache

This block sits between a processor port and a word-organised backing memory. Each cache line holds a single 32-bit word, and there are two ways per set. A 32-bit byte address is split into three parts: a byte offset, a set index and a tag. The tags of both ways in the indexed set are compared at the same time.

On a read hit, the word is returned in the same cycle the request is presented. A read miss fetches the word from backing memory and places it in the way that was not used most recently. The set's recency bit is then updated. Writes go through to memory every time. A write that hits also refreshes the cached copy, and a write that misses leaves the cache unchanged. Two counters report completed hits and misses.

The processor raises `cpu_req` and holds the address, write flag and write data until `cpu_ready` is seen high at a clock edge. Backing memory takes `mem_req` with a word address and answers with a one-cycle `mem_ack`.

Top module: `cache2w_top`

## Requirements
- R1: Reset invalidates every line and clears both counters. After reset, `cpu_ready` and `mem_req` are low, and the first access to any address is a miss.
- R2: Address bits [1:0] play no part in lookup. The set is the word address (bits [31:2]) modulo the number of sets, taken from bits [2+SET_W-1:2]. The tag is every bit above the set field. The memory word address is `cpu_addr[31:2]`.
- R3: A read miss keeps `cpu_ready` low and drives `mem_req` high with `mem_we` low, starting the cycle after the request is accepted. In the cycle `mem_ack` is high, `cpu_ready` is high and `cpu_rdata` equals `mem_rdata`.
- R4: A read hit raises `cpu_ready` in the same cycle as the request and returns the word of the matching way, with no memory request. `cpu_rdata` is zero unless a hit has been decided or a fill is completing.
- R5: A fill goes into the way of the set that was not used last. Reset marks way 1 as last used in every set. Every read hit, write hit and fill marks its way as last used.
- R6: A write that hits updates the cached word. It is also sent to memory: `mem_req` and `mem_we` go high with `mem_wdata` equal to the written data. `cpu_ready` rises in the `mem_ack` cycle.
- R7: A write that misses goes to memory only. No line is filled or evicted, so a later read of that word misses and the other lines of the set still hit.
- R8: `hit_count` rises by one for each completed read hit or write hit. `miss_count` rises by one for each completed read miss or write miss. The two never rise in the same cycle.
- R9: From an empty cache, the word sequence 0,4,0,4,0,4,0,4 gives exactly 2 misses and 6 hits.
- R10: Sets are independent. Fills in one set never evict a line of another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until accepted |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` on reads |
| mem_req | output | 1 | Backing memory request |
| mem_we | output | 1 | Backing memory write |
| mem_addr | output | 30 | Backing memory word address |
| mem_wdata | output | 32 | Backing memory write data |
| mem_ack | input | 1 | Memory response, one cycle |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| hit_count | output | CNT_W | Completed hits |
| miss_count | output | CNT_W | Completed misses |

## Verification
A read hit is due in the same cycle the request appears. Read misses and all writes are due in the cycle the memory model raises `mem_ack`, two cycles after `mem_req` first shows. The counters move at the clock edge that ends each access.

The bench drives a request at a falling edge. Its monitor samples one nanosecond before each rising edge. It takes a result only when `cpu_req` and `cpu_ready` are both high, and compares that result with the expected item at the head of the scoreboard queue. Whether the access hit is read from whether a memory read appeared during the transaction. Counter values are checked only after the driver has seen the closing edge.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
    localparam int ADDR_W  = 32;
    localparam int WORD_W  = 32;
    localparam int OFF_W   = 2;
    localparam int WADDR_W = ADDR_W - OFF_W;
    localparam int WAYS    = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WRITE = 2'd2
    } ctl_state_e;

    // one write into the line store: which way, and the word it receives
    typedef struct packed {
        logic              en;
        logic              way;
        logic [WORD_W-1:0] data;
    } line_wr_t;

    function automatic logic other_way(input logic w);
        return ~w;
    endfunction
endpackage

// File: rtl/cache2w_addr_split.sv
module cache2w_addr_split
    import cache2w_pkg::*;
#(
    parameter int SET_W = 2,
    localparam int TAG_W = WADDR_W - SET_W
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [SET_W-1:0]   set_idx,
    output logic [TAG_W-1:0]   tag,
    output logic [WADDR_W-1:0] word_addr
);
    logic [OFF_W-1:0] unused_byte_off;

    assign unused_byte_off = addr[OFF_W-1:0];
    assign word_addr       = addr[ADDR_W-1:OFF_W];
    assign set_idx         = word_addr[SET_W-1:0];
    assign tag             = word_addr[WADDR_W-1:SET_W];
endmodule

// File: rtl/cache2w_line_store.sv
module cache2w_line_store
    import cache2w_pkg::*;
#(
    parameter int SETS  = 4,
    parameter int TAG_W = 28,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [SET_W-1:0]            set_idx,
    input  logic [TAG_W-1:0]            tag,
    input  line_wr_t                    wr,
    output logic [WAYS-1:0]             hit_vec,
    output logic [WAYS-1:0][WORD_W-1:0] way_word
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic              vld  [SETS];
        logic [TAG_W-1:0]  tags [SETS];
        logic [WORD_W-1:0] words[SETS];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int s = 0; s < SETS; s++) begin
                    vld[s] <= 1'b0;
                end
            end else if (wr.en && (wr.way == 1'(w))) begin
                vld[set_idx] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (wr.en && (wr.way == 1'(w))) begin
                tags[set_idx]  <= tag;
                words[set_idx] <= wr.data;
            end
        end

        assign hit_vec[w]  = vld[set_idx] && (tags[set_idx] == tag);
        assign way_word[w] = words[set_idx];
    end
endmodule

// File: rtl/cache2w_recency.sv
module cache2w_recency
    import cache2w_pkg::*;
#(
    parameter int SETS = 4,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] set_idx,
    input  logic             touch,
    input  logic             touch_way,
    output logic             victim
);
    logic [SETS-1:0] last_used;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_used <= '1;
        end else if (touch) begin
            last_used[set_idx] <= touch_way;
        end
    end

    assign victim = other_way(last_used[set_idx]);
endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
    import cache2w_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_req,
    input  logic             cpu_we,
    input  logic             hit,
    input  logic             mem_ack,
    output logic             cpu_ready,
    output logic             mem_req,
    output logic             mem_we,
    output logic             rd_hit,
    output logic             fill_en,
    output logic             whit_en,
    output logic             touch,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count
);
    ctl_state_e state, state_nx;
    logic       wr_done, bump_hit, bump_miss;

    assign rd_hit    = (state == ST_IDLE) && cpu_req && !cpu_we && hit;
    assign fill_en   = (state == ST_FILL) && mem_ack;
    assign wr_done   = (state == ST_WRITE) && mem_ack;
    assign whit_en   = wr_done && hit;
    assign cpu_ready = rd_hit || fill_en || wr_done;
    assign mem_req   = (state != ST_IDLE);
    assign mem_we    = (state == ST_WRITE);
    assign touch     = rd_hit || fill_en || whit_en;
    assign bump_hit  = rd_hit || whit_en;
    assign bump_miss = fill_en || (wr_done && !hit);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (cpu_req && cpu_we) begin
                    state_nx = ST_WRITE;
                end else if (cpu_req && !hit) begin
                    state_nx = ST_FILL;
                end
            end
            ST_FILL:  if (mem_ack) state_nx = ST_IDLE;
            ST_WRITE: if (mem_ack) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            hit_count  <= '0;
            miss_count <= '0;
        end else begin
            state <= state_nx;
            if (bump_hit)  hit_count  <= hit_count + 1'b1;
            if (bump_miss) miss_count <= miss_count + 1'b1;
        end
    end
endmodule

// File: rtl/cache2w_top.sv
module cache2w_top
    import cache2w_pkg::*;
#(
    parameter int SETS  = 4,
    parameter int CNT_W = 16,
    localparam int SET_W = $clog2(SETS),
    localparam int TAG_W = WADDR_W - SET_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [WORD_W-1:0]  cpu_wdata,
    output logic               cpu_ready,
    output logic [WORD_W-1:0]  cpu_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [WADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    input  logic               mem_ack,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic [CNT_W-1:0]   hit_count,
    output logic [CNT_W-1:0]   miss_count
);
    logic [SET_W-1:0]            set_idx;
    logic [TAG_W-1:0]            tag;
    logic [WAYS-1:0]             hit_vec;
    logic [WAYS-1:0][WORD_W-1:0] way_word;
    logic                        hit, hit_way, victim;
    logic                        rd_hit, fill_en, whit_en, touch;
    line_wr_t                    line_wr;

    cache2w_addr_split #(.SET_W(SET_W)) u_split (
        .addr      (cpu_addr),
        .set_idx   (set_idx),
        .tag       (tag),
        .word_addr (mem_addr)
    );

    cache2w_line_store #(.SETS(SETS), .TAG_W(TAG_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .set_idx  (set_idx),
        .tag      (tag),
        .wr       (line_wr),
        .hit_vec  (hit_vec),
        .way_word (way_word)
    );

    cache2w_recency #(.SETS(SETS)) u_rec (
        .clk       (clk),
        .rst       (rst),
        .set_idx   (set_idx),
        .touch     (touch),
        .touch_way (fill_en ? victim : hit_way),
        .victim    (victim)
    );

    cache2w_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .hit        (hit),
        .mem_ack    (mem_ack),
        .cpu_ready  (cpu_ready),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .rd_hit     (rd_hit),
        .fill_en    (fill_en),
        .whit_en    (whit_en),
        .touch      (touch),
        .hit_count  (hit_count),
        .miss_count (miss_count)
    );

    assign hit     = |hit_vec;
    assign hit_way = hit_vec[1];

    assign line_wr.en   = fill_en || whit_en;
    assign line_wr.way  = fill_en ? victim : hit_way;
    assign line_wr.data = fill_en ? mem_rdata : cpu_wdata;

    assign mem_wdata = cpu_wdata;

    // word leaves only once the way is known
    always_comb begin
        if (rd_hit) begin
            cpu_rdata = way_word[hit_way];
        end else if (fill_en) begin
            cpu_rdata = mem_rdata;
        end else begin
            cpu_rdata = '0;
        end
    end
endmodule

// File: rtl/cache2w_checker.sv
module cache2w_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cpu_req,
    input logic             cpu_we,
    input logic [31:0]      cpu_addr,
    input logic             cpu_ready,
    input logic [31:0]      cpu_rdata,
    input logic             mem_req,
    input logic             mem_we,
    input logic [29:0]      mem_addr,
    input logic             mem_ack,
    input logic [31:0]      mem_rdata,
    input logic [CNT_W-1:0] hit_count,
    input logic [CNT_W-1:0] miss_count,
    input logic [1:0]       hit_vec
);
    assert_counts_cleared_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (hit_count == '0) && (miss_count == '0));

    assert_word_addr_R2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr == cpu_addr[31:2]));

    assert_fill_return_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_ack) |-> (cpu_ready && (cpu_rdata == mem_rdata)));

    assert_ready_has_req_R4: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> cpu_req);

    assert_single_way_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    assert_write_through_R6: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_we && cpu_ready) |-> (mem_req && mem_we));

    assert_one_counter_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($stable(hit_count) || $stable(miss_count)));

    assert_miss_step_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($stable(miss_count) || (miss_count == $past(miss_count) + 1'b1)));
endmodule

bind cache2w_top cache2w_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .cpu_ready  (cpu_ready),
    .cpu_rdata  (cpu_rdata),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .hit_count  (hit_count),
    .miss_count (miss_count),
    .hit_vec    (hit_vec)
);

// File: tb/sim_cache2w_top.sv
module sim_cache2w_top;
    localparam int CNT_W = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [CNT_W-1:0] hit_count, miss_count;

    always #5 clk = ~clk;

    cache2w_top #(.SETS(4), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .hit_count(hit_count), .miss_count(miss_count)
    );

    typedef struct {
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
        logic        exp_hit;
        string       req;
    } item_t;

    item_t       sb[$];
    int          checks = 0, errors = 0;
    int          exp_hits = 0, exp_misses = 0;
    logic        done = 1'b0;
    logic        saw_mem = 1'b0;
    logic [31:0] backing[256];
    logic [31:0] shadow[256];

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // backing memory: answers two cycles after a request appears
    initial begin
        int wait_n = 0;
        for (int i = 0; i < 256; i++) backing[i] = 32'hC0DE_0000 | i;
        forever begin
            @(posedge clk);
            if (mem_ack) begin
                mem_ack <= 1'b0;
                if (mem_we) backing[mem_addr[7:0]] = mem_wdata;
            end else if (mem_req) begin
                wait_n++;
                if (wait_n == 2) begin
                    wait_n = 0;
                    mem_ack   <= 1'b1;
                    mem_rdata <= backing[mem_addr[7:0]];
                end
            end
        end
    end

    // monitor: samples 1 ns ahead of each rising edge
    initial begin
        forever begin
            @(negedge clk);
            #4;
            if (!rst && cpu_req && sb.size() > 0) begin
                if (mem_req) begin
                    saw_mem = 1'b1;
                    check(mem_addr == sb[0].addr[31:2], "R2", {sb[0].req, " mem word address"},
                          {2'b00, mem_addr}, {2'b00, sb[0].addr[31:2]});
                    check(mem_we == sb[0].we, sb[0].we ? "R6" : "R3", {sb[0].req, " mem_we"},
                          {31'd0, mem_we}, {31'd0, sb[0].we});
                    if (mem_we)
                        check(mem_wdata == sb[0].data, "R6", {sb[0].req, " mem_wdata"},
                              mem_wdata, sb[0].data);
                end
                if (cpu_ready) begin
                    item_t it;
                    it = sb.pop_front();
                    if (!it.we) begin
                        check(cpu_rdata == it.data, it.req, "read data", cpu_rdata, it.data);
                        check(saw_mem == !it.exp_hit, it.req, "hit (1) / miss (0)",
                              {31'd0, !saw_mem}, {31'd0, it.exp_hit});
                    end else begin
                        check(saw_mem, it.req, "write reached memory", {31'd0, saw_mem}, 32'd1);
                    end
                    saw_mem = 1'b0;
                    done    = 1'b1;
                end
            end
        end
    end

    // driver: pushes the expected item, then holds the request until taken
    task automatic access(input logic we, input int word, input logic [31:0] wdata,
                          input logic exp_hit, input string req);
        item_t it;
        @(negedge clk);
        it.we      = we;
        it.addr    = word * 4;
        it.data    = we ? wdata : shadow[word];
        it.exp_hit = exp_hit;
        it.req     = req;
        if (we) shadow[word] = wdata;
        if (exp_hit) exp_hits++; else exp_misses++;
        sb.push_back(it);
        done      = 1'b0;
        cpu_req   = 1'b1;
        cpu_we    = we;
        cpu_addr  = it.addr;
        cpu_wdata = wdata;
        wait (done == 1'b1);
        @(negedge clk);
        cpu_req = 1'b0;
        cpu_we  = 1'b0;
    endtask

    task automatic rd(input int word, input logic exp_hit, input string req);
        access(1'b0, word, 32'd0, exp_hit, req);
    endtask

    task automatic read_byte(input logic [31:0] byte_addr, input string req);
        item_t it;
        @(negedge clk);
        it.we = 1'b0; it.addr = byte_addr; it.data = shadow[byte_addr[9:2]];
        it.exp_hit = 1'b1; it.req = req;
        exp_hits++;
        sb.push_back(it);
        done = 1'b0; cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = byte_addr;
        wait (done == 1'b1);
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) shadow[i] = 32'hC0DE_0000 | i;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        check(!cpu_ready && !mem_req, "R1", "idle after reset",
              {30'd0, cpu_ready, mem_req}, 32'd0);
        check(hit_count == 0 && miss_count == 0, "R1", "counters after reset",
              {hit_count, miss_count}, 32'd0);

        // R9: ping-pong words in one set (also R1: first touch misses)
        for (int k = 0; k < 4; k++) begin
            rd(0, k > 0, k == 0 ? "R1" : "R9");
            rd(4, k > 0, "R9");
        end
        check(miss_count == 2 && hit_count == 6, "R9", "misses/hits after 8 accesses",
              {hit_count, miss_count}, {16'd6, 16'd2});

        // R2: byte offset does not affect lookup
        read_byte(32'd1, "R2");
        read_byte(32'd3, "R2");

        // R5: victim is the way not used last (set 0 holds 0 in way0, 4 in way1, way0 last)
        rd(8, 1'b0, "R5");
        rd(0, 1'b1, "R5");
        rd(4, 1'b0, "R5");
        rd(8, 1'b0, "R5");
        rd(4, 1'b1, "R5");
        rd(0, 1'b0, "R5");

        // R10: set 1 fills leave set 0 intact
        rd(1, 1'b0, "R10");
        rd(5, 1'b0, "R10");
        rd(0, 1'b1, "R10");
        rd(4, 1'b1, "R10");
        rd(1, 1'b1, "R10");

        // R6: write hit updates cache and memory
        access(1'b1, 0, 32'hDEAD_BEEF, 1'b1, "R6");
        rd(0, 1'b1, "R6");
        check(backing[0] == 32'hDEAD_BEEF, "R6", "memory copy", backing[0], 32'hDEAD_BEEF);

        // R7: write miss fills nothing
        access(1'b1, 12, 32'h1234_5678, 1'b0, "R7");
        rd(4, 1'b1, "R7");
        rd(0, 1'b1, "R7");
        rd(12, 1'b0, "R7");

        // R8: counters match the tally of expected outcomes
        check(hit_count == CNT_W'(exp_hits), "R8", "hit_count",
              {16'd0, hit_count}, exp_hits);
        check(miss_count == CNT_W'(exp_misses), "R8", "miss_count",
              {16'd0, miss_count}, exp_misses);

        summary();
        $finish;
    end
endmodule